// File: doc/BRIEF.md
# Home Directory Controller for an MSI Protocol

This block sits at the home node of a shared memory system whose caches talk to it over a point-to-point network that does not keep messages in order. It keeps a small internal memory array. For every line it tracks a coherence state, a bit vector of the caches that hold a copy, the identity of the single writer, and the bookkeeping needed while a request is still in flight. Caches send it read, read-for-modify, upgrade and writeback requests. They also send the responses it asks for: data returned by an owner, and acknowledgements of invalidation. The block answers with data, invalidations, upgrade notices, forwarded requests and refusals.

All traffic enters through one message port, at most one message per cycle. Each accepted message produces at most one outgoing message, registered, on the following cycle. A multicast message carries a destination bit mask, one bit per cache. While a line waits for acknowledgements or for owner data, the home node orders all other traffic to that line: any new request to it is refused, and the requester must retry. Lines that are not waiting are served normally.

Top module: `home_directory`

## Requirements
- R1: After reset every line is uncached, its memory word holds zero, and `out_valid` is low.
- R2: A read (in_kind 0) to an uncached or shared line returns DATA (out_kind 0) with the memory word to the requester alone. The line becomes shared with the requester added to its sharer set.
- R3: A read-for-modify (in_kind 1) to an uncached line returns DATA with the memory word to the requester. The line becomes modified, with the requester as its only holder and owner.
- R4: A read-for-modify to a shared line sends INV (out_kind 1) to every sharer except the requester. After the last acknowledgement, memory DATA goes to the requester and the line becomes modified with the requester as owner. If no other sharer exists, the DATA reply is immediate.
- R5: An upgrade (in_kind 2) to a shared line sends UPG (out_kind 2) to every other sharer. After the last acknowledgement it grants the requester with DATA, and the line becomes modified. With no other sharers the grant is immediate. An upgrade to a line that is not shared is answered with NAK (out_kind 5).
- R6: A read to a modified line sends FWD_RD (out_kind 3) to the owner. When owner data (in_kind 4) returns from the owner, memory takes that data, DATA carrying it goes to the requester, and the line becomes shared by the old owner and the requester.
- R7: A read-for-modify to a modified line sends FWD_RDX (out_kind 4) to the owner. The owner data is passed to the requester as DATA, and the line stays modified with the requester as the new owner.
- R8: A writeback (in_kind 3) from the owner of a modified line writes memory, empties the sharer set, makes the line uncached and produces no message. A writeback from any other cache, or to a line in any other state, has no effect.
- R9: A request (in_kind 0 to 3) to a line that waits for acknowledgements or owner data gets NAK to the requester and changes nothing. Requests to other lines are served normally.
- R10: The acknowledgement counter is loaded with the number of sharers other than the requester. Each acknowledgement (in_kind 5) lowers it by one, and the transaction completes exactly on the last one. Acknowledgements or owner data that the line does not await, or owner data from a cache that is not the owner, are ignored.
- R11: Every outgoing message appears exactly one cycle after the incoming message that caused it. With no incoming message, `out_valid` is low. `out_data` is zero on messages other than DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message present |
| in_kind | input | 3 | 0 read, 1 read-for-modify, 2 upgrade, 3 writeback, 4 owner data, 5 acknowledgement |
| in_src | input | $clog2(N_CACHES) | Sending cache |
| in_line | input | $clog2(N_LINES) | Line index |
| in_data | input | DATA_W | Data for writeback and owner data |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 3 | 0 DATA, 1 INV, 2 UPG, 3 FWD_RD, 4 FWD_RDX, 5 NAK |
| out_dest | output | N_CACHES | Destination mask, one bit per cache |
| out_line | output | $clog2(N_LINES) | Line index |
| out_data | output | DATA_W | Data payload, zero unless DATA |

## Verification
Each reply, NAK included, is due on the cycle after the incoming message that caused it, because only the output register lies between input and port. A completion triggered by the last acknowledgement or by owner data is also due one cycle after that response. The bench drives each message on a falling edge, holds it for one rising edge, and then compares the outputs on the next falling edge. That puts every comparison exactly one register stage after its stimulus. Hidden state such as sharer sets, owners and memory contents is checked only through later requests, whose invalidation masks, forwarding targets and returned data expose it.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [2:0] {
    IN_RD   = 3'd0,
    IN_RDX  = 3'd1,
    IN_UPG  = 3'd2,
    IN_WB   = 3'd3,
    IN_ODAT = 3'd4,
    IN_ACK  = 3'd5
  } in_kind_e;

  typedef enum logic [2:0] {
    OUT_DATA = 3'd0,
    OUT_INV  = 3'd1,
    OUT_UPG  = 3'd2,
    OUT_FRD  = 3'd3,
    OUT_FRDX = 3'd4,
    OUT_NAK  = 3'd5
  } out_kind_e;

  // Stable states: uncached, shared, modified.
  // Waiting states: read waits owner data, rdx waits acks,
  // rdx waits owner data, upgrade waits acks.
  typedef enum logic [2:0] {
    DS_U   = 3'd0,
    DS_S   = 3'd1,
    DS_M   = 3'd2,
    DS_SWD = 3'd3,
    DS_MWA = 3'd4,
    DS_MWD = 3'd5,
    DS_MUA = 3'd6
  } dstate_e;

  function automatic logic is_waiting(input dstate_e s);
    return (s == DS_SWD) || (s == DS_MWA) || (s == DS_MWD) || (s == DS_MUA);
  endfunction

  function automatic logic is_request(input in_kind_e k);
    return (k == IN_RD) || (k == IN_RDX) || (k == IN_UPG) || (k == IN_WB);
  endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  parameter int DATA_W   = 16,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int CNT_W   = $clog2(N_CACHES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_W-1:0]   line,
  output dstate_e             rd_state,
  output logic [N_CACHES-1:0] rd_sharers,
  output logic [ID_W-1:0]     rd_owner,
  output logic [ID_W-1:0]     rd_pend,
  output logic [CNT_W-1:0]    rd_cnt,
  output logic [DATA_W-1:0]   rd_mem,
  input  logic                dir_we,
  input  dstate_e             wr_state,
  input  logic [N_CACHES-1:0] wr_sharers,
  input  logic [ID_W-1:0]     wr_owner,
  input  logic [ID_W-1:0]     wr_pend,
  input  logic [CNT_W-1:0]    wr_cnt,
  input  logic                mem_we,
  input  logic [DATA_W-1:0]   wr_mem
);

  dstate_e             state_q   [N_LINES];
  logic [N_CACHES-1:0] sharers_q [N_LINES];
  logic [ID_W-1:0]     owner_q   [N_LINES];
  logic [ID_W-1:0]     pend_q    [N_LINES];
  logic [CNT_W-1:0]    cnt_q     [N_LINES];
  logic [DATA_W-1:0]   mem_q     [N_LINES];

  assign rd_state   = state_q[line];
  assign rd_sharers = sharers_q[line];
  assign rd_owner   = owner_q[line];
  assign rd_pend    = pend_q[line];
  assign rd_cnt     = cnt_q[line];
  assign rd_mem     = mem_q[line];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state_q[g]   <= DS_U;
        sharers_q[g] <= '0;
        owner_q[g]   <= '0;
        pend_q[g]    <= '0;
        cnt_q[g]     <= '0;
        mem_q[g]     <= '0;
      end else if (line == LINE_W'(g)) begin
        if (dir_we) begin
          state_q[g]   <= wr_state;
          sharers_q[g] <= wr_sharers;
          owner_q[g]   <= wr_owner;
          pend_q[g]    <= wr_pend;
          cnt_q[g]     <= wr_cnt;
        end
        if (mem_we) mem_q[g] <= wr_mem;
      end
    end

    // R7: a modified line has exactly one holder, and it is the owner
    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q[g] == DS_M) |-> ($onehot(sharers_q[g]) && sharers_q[g][owner_q[g]]));

    // R10: a line waiting for acknowledgements always has some outstanding
    p_ack_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q[g] == DS_MWA || state_q[g] == DS_MUA) |-> (cnt_q[g] != '0));

    // R1: an uncached line has no holders
    p_uncached_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q[g] == DS_U) |-> (sharers_q[g] == '0));
  end

endmodule

// File: rtl/dir_protocol.sv
module dir_protocol
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int DATA_W   = 16,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int CNT_W   = $clog2(N_CACHES + 1)
) (
  input  logic                in_valid,
  input  in_kind_e            in_kind,
  input  logic [ID_W-1:0]     in_src,
  input  logic [DATA_W-1:0]   in_data,
  input  dstate_e             cur_state,
  input  logic [N_CACHES-1:0] cur_sharers,
  input  logic [ID_W-1:0]     cur_owner,
  input  logic [ID_W-1:0]     cur_pend,
  input  logic [CNT_W-1:0]    cur_cnt,
  input  logic [DATA_W-1:0]   cur_mem,
  output logic                dir_we,
  output dstate_e             nxt_state,
  output logic [N_CACHES-1:0] nxt_sharers,
  output logic [ID_W-1:0]     nxt_owner,
  output logic [ID_W-1:0]     nxt_pend,
  output logic [CNT_W-1:0]    nxt_cnt,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                msg_valid,
  output out_kind_e           msg_kind,
  output logic [N_CACHES-1:0] msg_dest,
  output logic [DATA_W-1:0]   msg_data,
  output logic                ev_refuse,
  output logic                ev_complete
);

  function automatic logic [CNT_W-1:0] count_holders(input logic [N_CACHES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < N_CACHES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [N_CACHES-1:0] id_mask(input logic [ID_W-1:0] id);
    return N_CACHES'(1) << id;
  endfunction

  logic [N_CACHES-1:0] src_bit, others;
  assign src_bit = id_mask(in_src);
  assign others  = cur_sharers & ~src_bit;

  always_comb begin
    dir_we      = 1'b0;
    nxt_state   = cur_state;
    nxt_sharers = cur_sharers;
    nxt_owner   = cur_owner;
    nxt_pend    = cur_pend;
    nxt_cnt     = cur_cnt;
    mem_we      = 1'b0;
    mem_wdata   = in_data;
    msg_valid   = 1'b0;
    msg_kind    = OUT_DATA;
    msg_dest    = '0;
    msg_data    = '0;
    ev_refuse   = 1'b0;
    ev_complete = 1'b0;

    if (in_valid && is_request(in_kind) && is_waiting(cur_state)) begin
      ev_refuse = 1'b1;
      msg_valid = 1'b1;
      msg_kind  = OUT_NAK;
      msg_dest  = src_bit;
    end else if (in_valid) begin
      unique case (in_kind)
        IN_RD: begin
          dir_we    = 1'b1;
          msg_valid = 1'b1;
          if (cur_state == DS_M) begin
            msg_kind  = OUT_FRD;
            msg_dest  = id_mask(cur_owner);
            nxt_pend  = in_src;
            nxt_state = DS_SWD;
          end else begin
            msg_dest    = src_bit;
            msg_data    = cur_mem;
            nxt_sharers = cur_sharers | src_bit;
            nxt_state   = DS_S;
          end
        end
        IN_RDX: begin
          dir_we    = 1'b1;
          msg_valid = 1'b1;
          if (cur_state == DS_M) begin
            msg_kind  = OUT_FRDX;
            msg_dest  = id_mask(cur_owner);
            nxt_pend  = in_src;
            nxt_state = DS_MWD;
          end else if (cur_state == DS_S && others != '0) begin
            msg_kind  = OUT_INV;
            msg_dest  = others;
            nxt_cnt   = count_holders(others);
            nxt_pend  = in_src;
            nxt_state = DS_MWA;
          end else begin
            msg_dest    = src_bit;
            msg_data    = cur_mem;
            nxt_sharers = src_bit;
            nxt_owner   = in_src;
            nxt_state   = DS_M;
          end
        end
        IN_UPG: begin
          msg_valid = 1'b1;
          msg_dest  = src_bit;
          if (cur_state != DS_S) begin
            msg_kind = OUT_NAK;
          end else if (others != '0) begin
            dir_we    = 1'b1;
            msg_kind  = OUT_UPG;
            msg_dest  = others;
            nxt_cnt   = count_holders(others);
            nxt_pend  = in_src;
            nxt_state = DS_MUA;
          end else begin
            dir_we      = 1'b1;
            msg_data    = cur_mem;
            nxt_sharers = src_bit;
            nxt_owner   = in_src;
            nxt_state   = DS_M;
          end
        end
        IN_WB: begin
          if (cur_state == DS_M && cur_owner == in_src) begin
            dir_we      = 1'b1;
            mem_we      = 1'b1;
            nxt_sharers = '0;
            nxt_state   = DS_U;
          end
        end
        IN_ODAT: begin
          if (cur_owner == in_src && (cur_state == DS_SWD || cur_state == DS_MWD)) begin
            dir_we      = 1'b1;
            ev_complete = 1'b1;
            msg_valid   = 1'b1;
            msg_dest    = id_mask(cur_pend);
            msg_data    = in_data;
            if (cur_state == DS_SWD) begin
              mem_we      = 1'b1;
              nxt_sharers = id_mask(cur_owner) | id_mask(cur_pend);
              nxt_state   = DS_S;
            end else begin
              nxt_sharers = id_mask(cur_pend);
              nxt_owner   = cur_pend;
              nxt_state   = DS_M;
            end
          end
        end
        IN_ACK: begin
          if (cur_state == DS_MWA || cur_state == DS_MUA) begin
            dir_we  = 1'b1;
            nxt_cnt = cur_cnt - CNT_W'(1);
            if (cur_cnt == CNT_W'(1)) begin
              ev_complete = 1'b1;
              msg_valid   = 1'b1;
              msg_dest    = id_mask(cur_pend);
              msg_data    = cur_mem;
              nxt_sharers = id_mask(cur_pend);
              nxt_owner   = cur_pend;
              nxt_state   = DS_M;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dir_msg_reg.sv
module dir_msg_reg
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  parameter int DATA_W   = 16,
  localparam int LINE_W  = $clog2(N_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msg_valid,
  input  out_kind_e           msg_kind,
  input  logic [N_CACHES-1:0] msg_dest,
  input  logic [LINE_W-1:0]   msg_line,
  input  logic [DATA_W-1:0]   msg_data,
  output logic                q_valid,
  output out_kind_e           q_kind,
  output logic [N_CACHES-1:0] q_dest,
  output logic [LINE_W-1:0]   q_line,
  output logic [DATA_W-1:0]   q_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_kind  <= OUT_DATA;
      q_dest  <= '0;
      q_line  <= '0;
      q_data  <= '0;
    end else begin
      q_valid <= msg_valid;
      q_kind  <= msg_kind;
      q_dest  <= msg_valid ? msg_dest : '0;
      q_line  <= msg_line;
      q_data  <= msg_valid ? msg_data : '0;
    end
  end

endmodule

// File: rtl/home_directory.sv
module home_directory
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 8,
  parameter int DATA_W   = 16,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int CNT_W   = $clog2(N_CACHES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_kind,
  input  logic [ID_W-1:0]     in_src,
  input  logic [LINE_W-1:0]   in_line,
  input  logic [DATA_W-1:0]   in_data,
  output logic                out_valid,
  output logic [2:0]          out_kind,
  output logic [N_CACHES-1:0] out_dest,
  output logic [LINE_W-1:0]   out_line,
  output logic [DATA_W-1:0]   out_data
);

  in_kind_e            kind_in;
  dstate_e             cur_state, nxt_state;
  logic [N_CACHES-1:0] cur_sharers, nxt_sharers;
  logic [ID_W-1:0]     cur_owner, nxt_owner, cur_pend, nxt_pend;
  logic [CNT_W-1:0]    cur_cnt, nxt_cnt;
  logic [DATA_W-1:0]   cur_mem, mem_wdata;
  logic                dir_we, mem_we;
  logic                msg_valid;
  out_kind_e           msg_kind, q_kind;
  logic [N_CACHES-1:0] msg_dest;
  logic [DATA_W-1:0]   msg_data;
  logic                ev_refuse, ev_complete;
  logic                req_on_waiting;

  assign kind_in        = in_kind_e'(in_kind);
  assign req_on_waiting = in_valid && is_request(kind_in) && is_waiting(cur_state);

  dir_store #(.N_CACHES(N_CACHES), .N_LINES(N_LINES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .line(in_line),
    .rd_state(cur_state), .rd_sharers(cur_sharers), .rd_owner(cur_owner),
    .rd_pend(cur_pend), .rd_cnt(cur_cnt), .rd_mem(cur_mem),
    .dir_we(dir_we), .wr_state(nxt_state), .wr_sharers(nxt_sharers),
    .wr_owner(nxt_owner), .wr_pend(nxt_pend), .wr_cnt(nxt_cnt),
    .mem_we(mem_we), .wr_mem(mem_wdata)
  );

  dir_protocol #(.N_CACHES(N_CACHES), .DATA_W(DATA_W)) u_proto (
    .in_valid(in_valid), .in_kind(kind_in), .in_src(in_src), .in_data(in_data),
    .cur_state(cur_state), .cur_sharers(cur_sharers), .cur_owner(cur_owner),
    .cur_pend(cur_pend), .cur_cnt(cur_cnt), .cur_mem(cur_mem),
    .dir_we(dir_we), .nxt_state(nxt_state), .nxt_sharers(nxt_sharers),
    .nxt_owner(nxt_owner), .nxt_pend(nxt_pend), .nxt_cnt(nxt_cnt),
    .mem_we(mem_we), .mem_wdata(mem_wdata),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
    .msg_data(msg_data), .ev_refuse(ev_refuse), .ev_complete(ev_complete)
  );

  dir_msg_reg #(.N_CACHES(N_CACHES), .N_LINES(N_LINES), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
    .msg_line(in_line), .msg_data(msg_data),
    .q_valid(out_valid), .q_kind(q_kind), .q_dest(out_dest),
    .q_line(out_line), .q_data(out_data)
  );

  assign out_kind = q_kind;

  // R11: nothing leaves without an incoming message one cycle earlier
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R9: a request to a waiting line is refused on the next cycle
  p_refuse_waiting_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_on_waiting) |-> (out_valid && q_kind == OUT_NAK && out_dest[$past(in_src)]));

  // R9: the refusal event never coincides with a state update
  p_refuse_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |-> (!dir_we && !mem_we));

  // R2: point-to-point replies name exactly one cache
  p_unicast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_kind != OUT_INV && q_kind != OUT_UPG) |-> $onehot(out_dest));

  // R10: invalidations and upgrade notices skip the requester and reach someone
  p_multicast_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (q_kind == OUT_INV || q_kind == OUT_UPG))
      |-> (out_dest != '0 && !out_dest[$past(in_src)]));

  // R10: a completion always produces a DATA reply one cycle later
  p_complete_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> (out_valid && q_kind == OUT_DATA));

  // R11: payload is zero on every non-DATA message
  p_payload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_kind != OUT_DATA) |-> (out_data == '0));

endmodule

// File: tb/tb_home_directory.sv
module tb_home_directory;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [1:0]  in_src = '0;
  logic [2:0]  in_line = '0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [2:0]  out_kind;
  logic [3:0]  out_dest;
  logic [2:0]  out_line;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  home_directory dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_src(in_src), .in_line(in_line), .in_data(in_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest),
    .out_line(out_line), .out_data(out_data)
  );

  // kind, src, line, data | expected valid, kind, dest mask, data | tag
  function automatic logic [51:0] v(int k, int s, int l, int d,
                                    int ev, int et, int ed, int edat, int tag);
    return {k[2:0], s[1:0], l[2:0], d[15:0], ev[0], et[2:0], ed[3:0], edat[15:0], tag[3:0]};
  endfunction

  localparam logic [51:0] VEC [NV] = '{
    v(0,0,1,0,      1,0,4'b0001,0,      2),   // R2 read of uncached
    v(0,2,1,0,      1,0,4'b0100,0,      2),   // R2 read of shared
    v(1,1,1,0,      1,1,4'b0101,0,      4),   // R4 invalidate both sharers
    v(0,3,1,0,      1,5,4'b1000,0,      9),   // R9 refused, line waiting
    v(0,3,2,0,      1,0,4'b1000,0,      9),   // R9 other line served
    v(5,0,1,0,      0,0,0,0,            10),  // R10 first ack, no reply
    v(5,2,1,0,      1,0,4'b0010,0,      4),   // R4 last ack, data to requester
    v(0,0,1,0,      1,3,4'b0010,0,      6),   // R6 forward read to owner 1
    v(4,1,1,16'h1234, 1,0,4'b0001,16'h1234, 6), // R6 owner data to reader
    v(2,0,1,0,      1,2,4'b0010,0,      5),   // R5 upgrade notice to cache 1
    v(5,1,1,0,      1,0,4'b0001,16'h1234, 5), // R5 grant after ack, memory written
    v(1,3,1,0,      1,4,4'b0001,0,      7),   // R7 forward rdx to owner 0
    v(4,2,1,16'h7777, 0,0,0,0,          10),  // R10 owner data from non-owner ignored
    v(4,0,1,16'hBEEF, 1,0,4'b1000,16'hBEEF, 7), // R7 owner data passed on
    v(3,2,1,16'h5555, 0,0,0,0,          8),   // R8 non-owner writeback ignored
    v(3,3,1,16'hCAFE, 0,0,0,0,          8),   // R8 owner writeback
    v(0,1,1,0,      1,0,4'b0010,16'hCAFE, 8), // R8 memory holds written data
    v(1,1,1,0,      1,0,4'b0010,16'hCAFE, 4), // R4 sole sharer gets data at once
    v(2,3,2,0,      1,0,4'b1000,0,      5),   // R5 sole sharer upgrade granted
    v(2,0,3,0,      1,5,4'b0001,0,      5),   // R5 upgrade to uncached refused
    v(5,1,3,0,      0,0,0,0,            10),  // R10 stray ack ignored
    v(4,1,3,16'h0007, 0,0,0,0,          10),  // R10 stray owner data ignored
    v(0,0,3,0,      1,0,4'b0001,0,      10),  // R10 memory untouched by stray data
    v(1,2,4,0,      1,0,4'b0100,0,      3),   // R3 rdx to uncached
    v(0,1,4,0,      1,3,4'b0100,0,      3),   // R3 owner is cache 2
    v(4,2,4,16'h0042, 1,0,4'b0010,16'h0042, 6), // R6 read completes
    v(1,0,4,0,      1,1,4'b0110,0,      10),  // R10 two acks expected
    v(5,1,4,0,      0,0,0,0,            10)   // R10 one ack left
  };

  task automatic check(input bit ok, input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input int k, input int s, input int l, input int d);
    @(negedge clk);
    in_valid = 1'b1;
    in_kind  = k[2:0];
    in_src   = s[1:0];
    in_line  = l[2:0];
    in_data  = d[15:0];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_msg(input int tag, input bit ev, input int et, input int ed,
                            input int edat, input int l);
    logic [31:0] act, exp;
    act = {out_valid, out_kind, out_dest, out_line, out_data};
    exp = {ev, et[2:0], ed[3:0], (ev ? l[2:0] : out_line), (ev ? edat[15:0] : out_data)};
    check(out_valid == ev && (!ev || (out_kind == et[2:0] && out_dest == ed[3:0]
          && out_line == l[2:0] && out_data == edat[15:0])), tag, "message", act, exp);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL R11 watchdog expired: actual 0 expected 1");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: no output while and right after reset
    check(out_valid == 1'b0, 1, "reset out_valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, 1, "after reset out_valid", 32'(out_valid), 0);
    // R1: every line uncached with zero memory
    send(0, 1, 7, 0);
    expect_msg(1, 1, 0, 4'b0010, 0, 7);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] e;
      e = VEC[i];
      send(int'(e[51:49]), int'(e[48:47]), int'(e[46:44]), int'(e[43:28]));
      expect_msg(int'(e[3:0]), e[27], int'(e[26:24]), int'(e[23:20]),
                 int'(e[19:4]), int'(e[46:44]));
    end

    // R11: idle input gives no output on the next cycle
    @(negedge clk);
    check(out_valid == 1'b0, 11, "idle out_valid", 32'(out_valid), 0);

    // R10: last ack on line 4 completes and grants cache 0
    send(5, 2, 4, 0);
    expect_msg(10, 1, 0, 4'b0001, 16'h0042, 4);

    // R1: reset clears directory and memory
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(0, 1, 4, 0);
    expect_msg(1, 1, 0, 4'b0010, 0, 4);
    send(0, 0, 1, 0);
    expect_msg(1, 1, 0, 4'b0001, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule